// File: doc/BRIEF.md
# Posted-Write Queue with Read Bypass

This block sits between an internal requester and an external bus master port. Writes are posted into a small queue and the requester moves on at once. The queue drains the writes to the external bus one cycle at a time, in the order they were accepted. Each queued write carries a flag saying whether it hit the cache. A read waiting on the requester's read port normally goes to the bus only once the queue is empty. A plain memory read may go ahead of the queued writes, but only when every queued write is flagged as a hit. When that happens, every queued write is marked as a miss, so the same set of writes can be passed only once.

The block also runs locked read-modify-write sequences. A locked read waits for an empty queue and raises the lock output. The block then waits for the requester to post the modified write, and the lock stays high until that write's bus cycle is acknowledged. I/O reads always wait for the queue to drain and are never marked cacheable. A cache-invalidate pulse marks all queued writes as misses. With the cache disabled, at most one write is held and no read can pass a write. The external bus uses a request/ready handshake with one cycle outstanding at a time.

Top module: `wbuf_bypass`

## Requirements
- R1: While and right after reset, bus_req, bus_lock and rd_done are 0 and wr_ready is 1 (cache enabled).
- R2: With the cache enabled the queue holds four writes; when four are held, wr_ready is 0 and no write is accepted.
- R3: Every accepted write appears on the bus exactly once, in acceptance order, with unchanged address, data and byte enables (bus_we=1).
- R4: With the bus idle and no read waiting, a write accepted at clock edge N raises bus_req with bus_we=1 after edge N+1.
- R5: A memory read (rd_io=0, rd_lock=0) with the cache enabled goes onto the bus ahead of queued writes when all of them are flagged as hits. Such a read drives bus_cache=1, and its data comes back on rd_rdata with a one-cycle rd_done pulse.
- R6: When a read passes queued writes, all writes queued at that moment become misses. The next read waits until those writes have all been issued.
- R7: A one-cycle inv pulse turns every queued write into a miss, so a following read waits until the queue is empty.
- R8: With cache_en=0, wr_ready is 1 only when the queue is empty, and no read passes a queued write.
- R9: A locked read (rd_lock=1) waits for an empty queue and drives bus_lock=1 and bus_cache=0. The next posted write is issued with bus_lock=1. bus_lock stays high until that write's bus cycle is acknowledged, then falls.
- R10: An I/O read (rd_io=1) waits until the queue is empty and drives bus_io=1 and bus_cache=0.
- R11: Once raised, bus_req and its address, data and direction stay stable until bus_rdy is sampled high. Only one bus cycle is outstanding at a time.
- R12: A read held behind queued writes is not lost: it is issued once it becomes eligible, and it returns the bus data for its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | 32 | Write address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| wr_hit | input | 1 | Write hit the cache |
| rd_valid | input | 1 | Read request, held until rd_done |
| rd_addr | input | 32 | Read address |
| rd_io | input | 1 | Read targets I/O space |
| rd_lock | input | 1 | Read starts a locked sequence |
| rd_done | output | 1 | One-cycle pulse, read data valid |
| rd_rdata | output | 32 | Read data |
| inv | input | 1 | Cache invalidation pulse |
| cache_en | input | 1 | Cache enabled |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_io | output | 1 | Bus cycle targets I/O space |
| bus_lock | output | 1 | Bus lock |
| bus_cache | output | 1 | Read data may be cached |
| bus_rdy | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 32 | Bus read data |

## Verification
The assertions check on every cycle several properties that a shadow count of queued writes can judge:
- no write is taken when the queue is full, or when the cache is off and a write is already held;
- I/O and locked reads start only on an empty queue;
- a second read never passes a set of writes that has already been passed;
- the lock is held until the locked write is acknowledged;
- a pending bus request stays stable.

Only the bench scenarios can show the actual ordering of bus cycles: that a read passes all-hit writes, that an invalidate or a disabled cache blocks the pass, and that the locked write carries the modified data. The bench also shows that writes leave the queue unchanged and in order under random traffic, and that a deferred read still returns its own data.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wentry_t;

    // Locked read-modify-write progress
    typedef enum logic [1:0] {
        LK_OFF,
        LK_RD,
        LK_HOLD,
        LK_WR
    } lkst_t;

    // A read may go to the bus when nothing is queued, or when it is a plain
    // cacheable memory read and every queued write is flagged as a hit.
    function automatic logic read_may_pass(
        input logic q_empty,
        input logic q_all_hit,
        input logic is_io,
        input logic is_lock,
        input logic cen
    );
        return q_empty || (q_all_hit && !is_io && !is_lock && cen);
    endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  wentry_t       push_ent,
    input  logic          push_hit,
    input  logic          pop,
    input  logic          clr_hit,
    output wentry_t       head,
    output logic [CW-1:0] count,
    output logic          all_hit
);
    // DEPTH must be a power of two: pointers wrap by overflow
    localparam int PW = $clog2(DEPTH);

    wentry_t          mem [DEPTH];
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] occ;
    logic [PW-1:0]    offs [DEPTH];
    logic [PW-1:0]    rp, wp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
            hit   <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
            for (int i = 0; i < DEPTH; i++) begin
                if (clr_hit)
                    hit[i] <= 1'b0;
                else if (push && wp == PW'(i))
                    hit[i] <= push_hit;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_occ
            assign offs[g] = PW'(g) - rp;
            assign occ[g]  = {1'b0, offs[g]} < count;
        end
    endgenerate

    assign all_hit = &(~occ | hit);
    assign head    = mem[rp];

endmodule

// File: rtl/wbuf_sched.sv
module wbuf_sched
    import wbuf_pkg::*;
(
    input  logic idle,
    input  logic rd_done,
    input  logic lk_busy,
    input  logic q_empty,
    input  logic q_all_hit,
    input  logic cache_en,
    input  logic rd_valid,
    input  logic rd_io,
    input  logic rd_lock,
    output logic go_rd,
    output logic go_wr,
    output logic go_bypass
);
    logic rd_ok;

    always_comb begin
        rd_ok     = rd_valid && !lk_busy &&
                    read_may_pass(q_empty, q_all_hit, rd_io, rd_lock, cache_en);
        go_rd     = idle && !rd_done && rd_ok;
        go_wr     = idle && !go_rd && !q_empty;
        go_bypass = go_rd && !q_empty;
    end

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              wr_hit,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_io,
    input  logic              rd_lock,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_rdata,
    input  logic              inv,
    input  logic              cache_en,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [BE_W-1:0]   bus_be,
    output logic              bus_io,
    output logic              bus_lock,
    output logic              bus_cache,
    input  logic              bus_rdy,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          push, pop, clr_hit;
    logic          go_rd, go_wr, go_bypass;
    logic          q_all_hit, q_empty;
    logic [CW-1:0] count;
    wentry_t       head, new_ent;
    lkst_t         lk;

    assign q_empty  = (count == '0);
    assign wr_ready = cache_en ? (count != CW'(DEPTH)) : q_empty;
    assign push     = wr_valid && wr_ready;
    assign new_ent  = '{addr: wr_addr, data: wr_data, be: wr_be};
    assign pop      = go_wr;
    assign clr_hit  = inv || go_bypass;

    wbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (new_ent),
        .push_hit (wr_hit && cache_en),
        .pop      (pop),
        .clr_hit  (clr_hit),
        .head     (head),
        .count    (count),
        .all_hit  (q_all_hit)
    );

    wbuf_sched u_sched (
        .idle      (!bus_req),
        .rd_done   (rd_done),
        .lk_busy   (lk != LK_OFF),
        .q_empty   (q_empty),
        .q_all_hit (q_all_hit),
        .cache_en  (cache_en),
        .rd_valid  (rd_valid),
        .rd_io     (rd_io),
        .rd_lock   (rd_lock),
        .go_rd     (go_rd),
        .go_wr     (go_wr),
        .go_bypass (go_bypass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_be    <= '0;
            bus_io    <= 1'b0;
            bus_lock  <= 1'b0;
            bus_cache <= 1'b0;
            rd_done   <= 1'b0;
            rd_rdata  <= '0;
            lk        <= LK_OFF;
        end else begin
            rd_done <= 1'b0;
            if (bus_req && bus_rdy) begin
                bus_req <= 1'b0;
                if (!bus_we) begin
                    rd_done  <= 1'b1;
                    rd_rdata <= bus_rdata;
                end
                case (lk)
                    LK_RD:   lk <= LK_HOLD;
                    LK_WR: begin
                        lk       <= LK_OFF;
                        bus_lock <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (go_rd) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b0;
                bus_addr  <= rd_addr;
                bus_wdata <= '0;
                bus_be    <= '1;
                bus_io    <= rd_io;
                bus_lock  <= rd_lock;
                bus_cache <= cache_en && !rd_io && !rd_lock;
                if (rd_lock) lk <= LK_RD;
            end else if (go_wr) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= head.addr;
                bus_wdata <= head.data;
                bus_be    <= head.be;
                bus_io    <= 1'b0;
                bus_cache <= 1'b0;
                if (lk == LK_HOLD) lk <= LK_WR;
            end
        end
    end

endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              cache_en,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_io,
    input logic              bus_lock,
    input logic              bus_cache,
    input logic              bus_rdy
);
    localparam int OW = $clog2(DEPTH) + 2;

    logic          prev_req;
    logic [OW-1:0] occ, occ_d, remain, mirror;
    logic          wr_start, rd_start, acc;

    assign acc      = wr_valid && wr_ready;
    assign wr_start = bus_req && bus_we && !prev_req;
    assign rd_start = bus_req && !bus_we && !prev_req;
    assign mirror   = occ - OW'(wr_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_req <= 1'b0;
            occ      <= '0;
            occ_d    <= '0;
            remain   <= '0;
        end else begin
            prev_req <= bus_req;
            occ      <= occ + OW'(acc) - OW'(wr_start);
            occ_d    <= occ;
            if (rd_start && occ_d != '0)
                remain <= occ_d;
            else if (wr_start && remain != '0)
                remain <= remain - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cache_en && mirror == OW'(DEPTH)) |-> !wr_ready); // R2
    AST_NOCACHE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!cache_en && mirror != '0) |-> !wr_ready); // R8
    AST_PASS_ONCE: assert property (@(posedge clk) disable iff (rst)
        (rd_start && occ_d != '0) |-> remain == '0); // R6
    AST_IO_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (rd_start && bus_io) |-> (occ_d == '0 && !bus_cache)); // R10
    AST_LOCK_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (rd_start && bus_lock) |-> occ_d == '0); // R9
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && !(bus_req && bus_we && bus_rdy)) |=> bus_lock); // R9
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata))); // R11

endmodule

bind wbuf_bypass wbuf_bypass_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .cache_en  (cache_en),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_io    (bus_io),
    .bus_lock  (bus_lock),
    .bus_cache (bus_cache),
    .bus_rdy   (bus_rdy)
);

// File: tb/wbuf_bypass_bench.sv
`timescale 1ns/1ps
module wbuf_bypass_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 0, wr_hit = 0, rd_valid = 0, rd_io = 0, rd_lock = 0;
    logic        inv = 0, cache_en = 1, bus_rdy = 0;
    logic [31:0] wr_addr = 0, wr_data = 0, rd_addr = 0, bus_rdata = 0;
    logic [3:0]  wr_be = 0;
    logic        wr_ready, rd_done, bus_req, bus_we, bus_io, bus_lock, bus_cache;
    logic [31:0] rd_rdata, bus_addr, bus_wdata;
    logic [3:0]  bus_be;

    always #10 clk = ~clk;

    wbuf_bypass #(.DEPTH(4)) u_wbuf_bypass (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_hit(wr_hit),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_io(rd_io), .rd_lock(rd_lock),
        .rd_done(rd_done), .rd_rdata(rd_rdata), .inv(inv), .cache_en(cache_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_io(bus_io),
        .bus_lock(bus_lock), .bus_cache(bus_cache), .bus_rdy(bus_rdy),
        .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0, stall = 0, rmode = 0, wdone = 0;
    int dly = 0;

    // expected write order
    logic [31:0] ex_addr [512];
    logic [31:0] ex_data [512];
    logic [3:0]  ex_be   [512];
    int eh = 0, et = 0;

    // bus cycle log for directed scenarios
    logic        lg_we [32], lg_lock [32], lg_io [32], lg_cache [32];
    logic [31:0] lg_addr [32], lg_data [32];
    int n_log = 0;

    function automatic logic [31:0] rdfun(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5A5, a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_log(input int i, input logic we, input logic [31:0] a,
                              input string req);
        logic [32:0] act;
        act = (i < n_log) ? {lg_we[i], lg_addr[i]} : 33'h1FFFFFFFF;
        chk(act == {we, a}, req, 64'(act), 64'({we, a}));
    endtask

    // bus responder and monitor
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rdy) bus_rdy = 1'b0;
            else if (bus_req && !stall) begin
                if (dly != 0) dly--;
                else begin
                    bus_rdy   = 1'b1;
                    bus_rdata = rdfun(bus_addr);
                    if (n_log < 32) begin
                        lg_we[n_log] = bus_we;   lg_addr[n_log] = bus_addr;
                        lg_lock[n_log] = bus_lock; lg_io[n_log] = bus_io;
                        lg_cache[n_log] = bus_cache; lg_data[n_log] = bus_wdata;
                    end
                    n_log++;
                    if (bus_we) begin
                        if (eh == et) chk(0, "R3 unexpected write", 64'(bus_addr), 0);
                        else begin
                            chk(bus_addr == ex_addr[eh] && bus_wdata == ex_data[eh]
                                && bus_be == ex_be[eh], "R3 write order/content",
                                {bus_addr, bus_wdata}, {ex_addr[eh], ex_data[eh]});
                            eh++;
                        end
                    end
                    dly = rmode ? int'($urandom % 3) : 0;
                end
            end
        end
    end

    // call at a negedge; returns at the negedge after acceptance
    task automatic push_wr(input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be, input logic h);
        wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be; wr_hit = h;
        while (!wr_ready) @(negedge clk);
        ex_addr[et] = a; ex_data[et] = d; ex_be[et] = be; et++;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic do_read(input logic [31:0] a, input logic io, input logic lk,
                           output logic [31:0] dat);
        rd_valid = 1; rd_addr = a; rd_io = io; rd_lock = lk;
        @(negedge clk);
        while (!rd_done) @(negedge clk);
        dat = rd_rdata;
        rd_valid = 0; rd_io = 0; rd_lock = 0;
    endtask

    task automatic release_after(input int n);
        repeat (n) @(negedge clk);
        #1 stall = 0;
    endtask

    task automatic drain;
        int k = 0;
        while ((eh != et || bus_req || rd_valid) && k < 3000) begin
            @(negedge clk); k++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R11 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d1, d2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!bus_req && !bus_lock && !rd_done, "R1 outputs in reset",
            {bus_req, bus_lock, rd_done}, 0);
        rst = 0;
        @(negedge clk);
        chk(wr_ready && !bus_req, "R1 after reset", {wr_ready, bus_req}, 2'b10);

        // R4: immediate issue on idle bus
        stall = 1;
        push_wr(32'h400, 32'h11, 4'hF, 1);
        chk(!bus_req, "R4 not yet issued", bus_req, 0);
        @(negedge clk);
        chk(bus_req && bus_we && bus_addr == 32'h400, "R4 issued next cycle",
            {bus_req, bus_we, bus_addr}, {2'b11, 32'h400});
        stall = 0; drain();

        // R5: read passes all-hit writes
        n_log = 0; stall = 1;
        push_wr(32'h100, 32'hA0, 4'hF, 1); push_wr(32'h104, 32'hA1, 4'h3, 1);
        push_wr(32'h108, 32'hA2, 4'hF, 1); push_wr(32'h10C, 32'hA3, 4'hC, 1);
        fork do_read(32'h800, 0, 0, d1); release_after(3); join
        drain();
        expect_log(0, 1, 32'h100, "R5 slot0"); expect_log(1, 0, 32'h800, "R5 read passes");
        expect_log(2, 1, 32'h104, "R5 slot2"); expect_log(4, 1, 32'h10C, "R5 slot4");
        chk(lg_cache[1], "R5 cacheable read", lg_cache[1], 1);
        chk(d1 == rdfun(32'h800), "R5 read data", d1, rdfun(32'h800));

        // R6: only one pass per set of writes
        n_log = 0; stall = 1;
        push_wr(32'h200, 32'hB0, 4'hF, 1); push_wr(32'h204, 32'hB1, 4'hF, 1);
        push_wr(32'h208, 32'hB2, 4'hF, 1); push_wr(32'h20C, 32'hB3, 4'hF, 1);
        fork begin do_read(32'h820, 0, 0, d1); do_read(32'h840, 0, 0, d2); end
             release_after(3); join
        drain();
        expect_log(1, 0, 32'h820, "R6 first read passes");
        expect_log(2, 1, 32'h204, "R6 re-flagged write");
        expect_log(4, 1, 32'h20C, "R6 re-flagged write last");
        expect_log(5, 0, 32'h840, "R6 second read waits");
        chk(d2 == rdfun(32'h840), "R12 deferred read data", d2, rdfun(32'h840));

        // R7: invalidate blocks the pass
        n_log = 0; stall = 1;
        push_wr(32'h300, 32'hC0, 4'hF, 1); push_wr(32'h304, 32'hC1, 4'hF, 1);
        push_wr(32'h308, 32'hC2, 4'hF, 1);
        inv = 1; @(negedge clk); inv = 0;
        fork do_read(32'h860, 0, 0, d1); release_after(3); join
        drain();
        expect_log(2, 1, 32'h308, "R7 writes first"); expect_log(3, 0, 32'h860, "R7 read last");

        // R10: I/O read waits and is not cacheable
        n_log = 0; stall = 1;
        push_wr(32'h500, 32'hD0, 4'hF, 1); push_wr(32'h504, 32'hD1, 4'hF, 1);
        push_wr(32'h508, 32'hD2, 4'hF, 1);
        fork do_read(32'h60, 1, 0, d1); release_after(3); join
        drain();
        expect_log(3, 0, 32'h60, "R10 io read after writes");
        chk(lg_io[3] && !lg_cache[3], "R10 io flags", {lg_io[3], lg_cache[3]}, 2'b10);

        // R9: locked read-modify-write
        n_log = 0; stall = 1;
        push_wr(32'h600, 32'hE0, 4'hF, 1); push_wr(32'h604, 32'hE1, 4'hF, 1);
        fork
            begin
                do_read(32'h900, 0, 1, d1);
                chk(bus_lock, "R9 lock held between read and write", bus_lock, 1);
                push_wr(32'h900, d1 + 1, 4'hF, 1);
            end
            release_after(3);
        join
        drain();
        expect_log(2, 0, 32'h900, "R9 locked read after drain");
        expect_log(3, 1, 32'h900, "R9 locked write");
        chk(lg_lock[2] && lg_lock[3] && !lg_lock[1] && !lg_cache[2], "R9 lock flags",
            {lg_lock[1], lg_lock[2], lg_lock[3], lg_cache[2]}, 4'b0110);
        chk(lg_data[3] == rdfun(32'h900) + 1, "R9 modified data", lg_data[3],
            rdfun(32'h900) + 1);
        chk(!bus_lock, "R9 lock released", bus_lock, 0);

        // R8: cache disabled
        cache_en = 0; n_log = 0; stall = 1;
        push_wr(32'h700, 32'hF0, 4'hF, 1);
        @(negedge clk);
        push_wr(32'h704, 32'hF1, 4'hF, 1);
        chk(!wr_ready, "R8 single write held", wr_ready, 0);
        fork do_read(32'h880, 0, 0, d1); release_after(3); join
        drain();
        expect_log(1, 1, 32'h704, "R8 write first"); expect_log(2, 0, 32'h880, "R8 no pass");
        cache_en = 1;

        // R2: four entries
        n_log = 0; stall = 1;
        for (int i = 0; i < 5; i++) push_wr(32'hA00 + 32'(i * 4), 32'(i), 4'hF, 0);
        chk(!wr_ready, "R2 full stalls writes", wr_ready, 0);
        chk(n_log == 0, "R2 nothing completed", 64'(n_log), 0);
        stall = 0;
        push_wr(32'hA40, 32'h55, 4'hF, 0);
        drain();
        chk(n_log == 6, "R2 all six drained", 64'(n_log), 6);

        // random traffic: R3 order, R12 read return
        rmode = 1;
        fork
            begin
                for (int i = 0; i < 150; i++) begin
                    push_wr({22'd0, 8'($urandom), 2'b00}, $urandom, 4'($urandom),
                            1'($urandom));
                    repeat ($urandom % 3) @(negedge clk);
                end
                wdone = 1;
            end
            begin
                for (int i = 0; i < 40; i++) begin
                    logic [31:0] a, dd;
                    a = {20'd0, 10'($urandom), 2'b00};
                    repeat ($urandom % 6) @(negedge clk);
                    do_read(a, ($urandom % 4) == 0, 0, dd);
                    chk(dd == rdfun(a), "R12 random read data", dd, rdfun(a));
                end
            end
            begin
                while (!wdone) begin
                    repeat (5 + $urandom % 20) @(negedge clk);
                    inv = 1; @(negedge clk); inv = 0;
                end
            end
        join
        drain();
        chk(eh == et, "R3 all writes issued", 64'(eh), 64'(et));

        finished = 1;
        summary();
        $finish;
    end

endmodule